// File: doc/BRIEF.md
# Register Field Update Arbiter

This block holds one field of a control/status register. Two agents can change it. The software port presents a write strobe, per-byte lane enables, bus-aligned write data and a read strobe. The hardware port presents a write enable, a next value, set and clear pulses, and a per-bit select vector. In every cycle the block collects the candidate updates from both ports and commits the one with the highest priority. The priority order is fixed and comes from a precedence parameter.

Parameters pick the field's position on the bus and its width. Other parameters pick the software write effect (plain, write-one-to-clear, write-one-to-set) and whether a read clears the field. They also pick single-pulse self-clearing, how the hardware bit select is read (ignored, enable or mask), the software write qualifier (none, active-high, active-low), whether a hardware write enable exists, and the reset style and value. The field value comes out on one port. The hardware side reads it there, and a register read mux reads it there too.

Top module: `regfld_arbiter`

## Requirements
- R1: With software precedence, one update is committed per cycle, in this order: qualified software write, then read clear, then hardware set/clear, then hardware write, then single-pulse clear. When none of these is active, the field holds its value.
- R2: With hardware precedence, one update is committed per cycle, in this order: hardware set/clear, then hardware write, then qualified software write, then read clear, then single-pulse clear. When none of these is active, the field holds its value.
- R3: In plain write mode, field bit i comes from bus bit FLD_LSB+i, and it changes only when `sw_be[(FLD_LSB+i)/8]` is high. Field bits in lanes that are not enabled keep their value. A qualified write with no enabled lane still takes its place in the priority order and leaves the field unchanged.
- R4: A hardware set forces every selected field bit to 1, and a hardware clear forces every selected bit to 0. If both arrive in the same cycle, set wins. Unselected bits keep their value.
- R5: The bit select applies to hardware set, clear and write. In enable mode, bit i is selected when `hw_bitsel[i]`=1. In mask mode, bit i is selected when `hw_bitsel[i]`=0. In the ignore mode, every bit is selected.
- R6: The software write qualifier works as follows. With the active-high qualifier, a write counts only when `sw_wen`=1. With the active-low qualifier, a write counts only when `sw_wen`=0. With no qualifier, `sw_wen` is ignored.
- R7: In write-one-to-clear mode, each field bit whose write data bit is 1 becomes 0. In write-one-to-set mode, each such bit becomes 1. Both modes act on the whole field and ignore the lane enables.
- R8: Reset loads RST_VAL. Reset can be active-high or active-low, and synchronous or asynchronous. An asynchronous reset takes effect before the next clock edge.
- R9: With hardware precedence and no hardware write enable, the field takes the hardware value, through the bit select, on every cycle without set/clear, and software writes have no effect.
- R10: In single-pulse mode, a bit written to 1 reads as 1 for one clock. It returns to 0 in the next cycle that has no other update.
- R11: In read-clear mode, a read strobe that wins its priority slot zeroes the field on the following clock edge. During the strobe cycle, the field still shows its value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset; polarity and synchronous/asynchronous style set by parameters |
| sw_wr | input | 1 | Software write strobe |
| sw_be | input | BUS_W/8 | Software byte-lane enables |
| sw_wdata | input | BUS_W | Software write data, aligned to the bus |
| sw_wen | input | 1 | Software write qualifier |
| sw_rd | input | 1 | Software read strobe |
| hw_we | input | 1 | Hardware write enable (unused when HW_WE_EN=0) |
| hw_d | input | FLD_W | Hardware next value |
| hw_set | input | 1 | Hardware set pulse |
| hw_clr | input | 1 | Hardware clear pulse |
| hw_bitsel | input | FLD_W | Per-bit hardware select (enable or mask) |
| fld_q | output | FLD_W | Current field value |

## Verification
The hardest cases to reach are those where three or more agents collide in one cycle. Examples are a qualified software write that lands on the same edge as a set, a clear and a hardware write, or a read-clear strobe that loses to a hardware update under hardware precedence. Random stimulus rarely lines these up on a chosen configuration. The bench therefore drives four instances with different parameter sets from the same stimulus, so every collision is seen under both precedence orders and several write and select modes at once. Directed steps then force the specific collisions, partial lane writes, the pre-clear read value and a mid-cycle asynchronous reset.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

    typedef enum logic {PREC_SW, PREC_HW} prec_e;
    typedef enum logic [1:0] {WFX_PLAIN, WFX_W1C, WFX_W1S} wfx_e;
    typedef enum logic [1:0] {SEL_ALL, SEL_ENABLE, SEL_MASK} hsel_e;
    typedef enum logic [1:0] {QUAL_NONE, QUAL_HIGH, QUAL_LOW} qual_e;

    // candidate update slots, index into the candidate vectors
    localparam int ACT_SWW = 0;  // software write
    localparam int ACT_SWR = 1;  // software read side effect
    localparam int ACT_HSC = 2;  // hardware set / clear
    localparam int ACT_HWW = 3;  // hardware write
    localparam int ACT_PLS = 4;  // single-pulse drop
    localparam int N_ACT   = 5;

    // action sitting at priority slot 'slot' (0 = highest)
    function automatic int slot_action(prec_e p, int slot);
        int a;
        if (p == PREC_SW) begin
            a = slot;
        end else begin
            case (slot)
                0:       a = ACT_HSC;
                1:       a = ACT_HWW;
                2:       a = ACT_SWW;
                3:       a = ACT_SWR;
                default: a = ACT_PLS;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/rfa_sw_side.sv
module rfa_sw_side
    import rfa_pkg::*;
#(
    parameter int    BUS_W   = 32,
    parameter int    FLD_LSB = 4,
    parameter int    FLD_W   = 12,
    parameter wfx_e  WFX     = WFX_PLAIN,
    parameter qual_e QUAL    = QUAL_HIGH,
    parameter bit    RD_CLR  = 1'b0
) (
    input  logic               sw_wr,
    input  logic [BUS_W/8-1:0] sw_be,
    input  logic [BUS_W-1:0]   sw_wdata,
    input  logic               sw_wen,
    input  logic               sw_rd,
    input  logic [FLD_W-1:0]   cur_q,
    output logic               wr_act,
    output logic [FLD_W-1:0]   wr_val,
    output logic               rd_act
);

    logic [FLD_W-1:0] wd_fld;
    logic             qual_ok;
    logic             unused_sw;

    assign wd_fld    = sw_wdata[FLD_LSB +: FLD_W];
    assign unused_sw = ^{sw_be, sw_wdata, sw_wen};

    generate
        if (QUAL == QUAL_HIGH) begin : g_qhi
            assign qual_ok = sw_wen;
        end else if (QUAL == QUAL_LOW) begin : g_qlo
            assign qual_ok = ~sw_wen;
        end else begin : g_qnone
            assign qual_ok = 1'b1;
        end
    endgenerate

    assign wr_act = sw_wr & qual_ok;
    assign rd_act = RD_CLR & sw_rd;

    generate
        if (WFX == WFX_W1C) begin : g_w1c
            assign wr_val = cur_q & ~wd_fld;
        end else if (WFX == WFX_W1S) begin : g_w1s
            assign wr_val = cur_q | wd_fld;
        end else begin : g_plain
            for (genvar i = 0; i < FLD_W; i++) begin : g_lane
                localparam int BUS_BIT = FLD_LSB + i;
                localparam int LANE    = BUS_BIT / 8;
                assign wr_val[i] = sw_be[LANE] ? sw_wdata[BUS_BIT] : cur_q[i];
            end
        end
    endgenerate

endmodule

// File: rtl/rfa_hw_side.sv
module rfa_hw_side
    import rfa_pkg::*;
#(
    parameter int    FLD_W    = 12,
    parameter hsel_e HSEL     = SEL_ENABLE,
    parameter bit    HW_WE_EN = 1'b1
) (
    input  logic             hw_we,
    input  logic [FLD_W-1:0] hw_d,
    input  logic             hw_set,
    input  logic             hw_clr,
    input  logic [FLD_W-1:0] hw_bitsel,
    input  logic [FLD_W-1:0] cur_q,
    output logic             sc_act,
    output logic [FLD_W-1:0] sc_val,
    output logic             wr_act,
    output logic [FLD_W-1:0] wr_val
);

    logic [FLD_W-1:0] sel;
    logic             unused_hw;

    assign unused_hw = ^{hw_bitsel, hw_we};

    generate
        if (HSEL == SEL_ENABLE) begin : g_en
            assign sel = hw_bitsel;
        end else if (HSEL == SEL_MASK) begin : g_mask
            assign sel = ~hw_bitsel;
        end else begin : g_all
            assign sel = '1;
        end

        if (HW_WE_EN) begin : g_we
            assign wr_act = hw_we;
        end else begin : g_always
            assign wr_act = 1'b1;
        end
    endgenerate

    assign sc_act = hw_set | hw_clr;
    assign sc_val = hw_set ? (cur_q | sel) : (cur_q & ~sel);
    assign wr_val = (cur_q & ~sel) | (hw_d & sel);

endmodule

// File: rtl/rfa_pick.sv
module rfa_pick
    import rfa_pkg::*;
#(
    parameter int    FLD_W = 12,
    parameter prec_e PREC  = PREC_SW
) (
    input  logic [N_ACT-1:0]            cand_act,
    input  logic [N_ACT-1:0][FLD_W-1:0] cand_val,
    input  logic [FLD_W-1:0]            cur_q,
    output logic [FLD_W-1:0]            nxt_q
);

    // walk from lowest to highest priority so the highest active slot lands last
    always_comb begin
        nxt_q = cur_q;
        for (int s = N_ACT - 1; s >= 0; s--) begin
            if (cand_act[slot_action(PREC, s)]) begin
                nxt_q = cand_val[slot_action(PREC, s)];
            end
        end
    end

endmodule

// File: rtl/rfa_store.sv
module rfa_store #(
    parameter int               FLD_W     = 12,
    parameter logic [FLD_W-1:0] RST_VAL   = '0,
    parameter bit               RST_ASYNC = 1'b0,
    parameter bit               RST_LOW   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FLD_W-1:0] d,
    output logic [FLD_W-1:0] q
);

    logic rst_act;
    assign rst_act = RST_LOW ? ~rst : rst;

    generate
        if (RST_ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst_act) begin
                if (rst_act) q <= RST_VAL;
                else         q <= d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst_act) q <= RST_VAL;
                else         q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/regfld_arbiter.sv
module regfld_arbiter
    import rfa_pkg::*;
#(
    parameter int               BUS_W     = 32,
    parameter int               FLD_LSB   = 4,
    parameter int               FLD_W     = 12,
    parameter logic [FLD_W-1:0] RST_VAL   = 'h5A3,
    parameter prec_e            PREC      = PREC_SW,
    parameter wfx_e             WFX       = WFX_PLAIN,
    parameter bit               RD_CLR    = 1'b0,
    parameter bit               PULSE     = 1'b0,
    parameter bit               HW_WE_EN  = 1'b1,
    parameter hsel_e            HSEL      = SEL_ENABLE,
    parameter qual_e            QUAL      = QUAL_HIGH,
    parameter bit               RST_ASYNC = 1'b0,
    parameter bit               RST_LOW   = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_wr,
    input  logic [BUS_W/8-1:0] sw_be,
    input  logic [BUS_W-1:0]   sw_wdata,
    input  logic               sw_wen,
    input  logic               sw_rd,
    input  logic               hw_we,
    input  logic [FLD_W-1:0]   hw_d,
    input  logic               hw_set,
    input  logic               hw_clr,
    input  logic [FLD_W-1:0]   hw_bitsel,
    output logic [FLD_W-1:0]   fld_q
);

    logic [N_ACT-1:0]            cand_act;
    logic [N_ACT-1:0][FLD_W-1:0] cand_val;
    logic [FLD_W-1:0]            nxt_q;

    rfa_sw_side #(
        .BUS_W(BUS_W), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W),
        .WFX(WFX), .QUAL(QUAL), .RD_CLR(RD_CLR)
    ) u_sw (
        .sw_wr(sw_wr), .sw_be(sw_be), .sw_wdata(sw_wdata),
        .sw_wen(sw_wen), .sw_rd(sw_rd), .cur_q(fld_q),
        .wr_act(cand_act[ACT_SWW]), .wr_val(cand_val[ACT_SWW]),
        .rd_act(cand_act[ACT_SWR])
    );

    rfa_hw_side #(
        .FLD_W(FLD_W), .HSEL(HSEL), .HW_WE_EN(HW_WE_EN)
    ) u_hw (
        .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set), .hw_clr(hw_clr),
        .hw_bitsel(hw_bitsel), .cur_q(fld_q),
        .sc_act(cand_act[ACT_HSC]), .sc_val(cand_val[ACT_HSC]),
        .wr_act(cand_act[ACT_HWW]), .wr_val(cand_val[ACT_HWW])
    );

    assign cand_val[ACT_SWR] = '0;
    assign cand_act[ACT_PLS] = PULSE;
    assign cand_val[ACT_PLS] = '0;

    rfa_pick #(.FLD_W(FLD_W), .PREC(PREC)) u_pick (
        .cand_act(cand_act), .cand_val(cand_val),
        .cur_q(fld_q), .nxt_q(nxt_q)
    );

    rfa_store #(
        .FLD_W(FLD_W), .RST_VAL(RST_VAL),
        .RST_ASYNC(RST_ASYNC), .RST_LOW(RST_LOW)
    ) u_store (
        .clk(clk), .rst(rst), .d(nxt_q), .q(fld_q)
    );

endmodule

// File: rtl/rfa_chk.sv
module rfa_chk
    import rfa_pkg::*;
#(
    parameter int               BUS_W    = 32,
    parameter int               FLD_W    = 12,
    parameter logic [FLD_W-1:0] RST_VAL  = '0,
    parameter prec_e            PREC     = PREC_SW,
    parameter wfx_e             WFX      = WFX_PLAIN,
    parameter bit               RD_CLR   = 1'b0,
    parameter bit               PULSE    = 1'b0,
    parameter bit               HW_WE_EN = 1'b1,
    parameter hsel_e            HSEL     = SEL_ENABLE,
    parameter qual_e            QUAL     = QUAL_HIGH,
    parameter bit               RST_LOW  = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               sw_wr,
    input logic [BUS_W/8-1:0] sw_be,
    input logic [FLD_W-1:0]   wd_fld,
    input logic               sw_wen,
    input logic               sw_rd,
    input logic               hw_we,
    input logic [FLD_W-1:0]   hw_d,
    input logic               hw_set,
    input logic               hw_clr,
    input logic [FLD_W-1:0]   fld_q
);

    logic rst_act, qual_ok, sww, hww, rdc;

    assign rst_act = RST_LOW ? ~rst : rst;
    assign qual_ok = (QUAL == QUAL_NONE) ? 1'b1 : (QUAL == QUAL_HIGH) ? sw_wen : ~sw_wen;
    assign sww     = sw_wr & qual_ok;
    assign hww     = HW_WE_EN ? hw_we : 1'b1;
    assign rdc     = RD_CLR & sw_rd;

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst_act)
        (PREC == PREC_SW && sww && WFX == WFX_PLAIN && (&sw_be)) |=> fld_q == $past(wd_fld)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst_act)
        (!sww && !rdc && !hw_set && !hw_clr && !hww && !PULSE) |=> $stable(fld_q)); // R1

    AST_HW_WINS: assert property (@(posedge clk) disable iff (rst_act)
        (PREC == PREC_HW && hww && !hw_set && !hw_clr && HSEL == SEL_ALL) |=> fld_q == $past(hw_d)); // R2

    AST_SET_ALL: assert property (@(posedge clk) disable iff (rst_act)
        (hw_set && HSEL == SEL_ALL && (PREC == PREC_HW || (!sww && !rdc))) |=> (&fld_q)); // R4

    AST_HW_STREAM: assert property (@(posedge clk) disable iff (rst_act)
        (PREC == PREC_HW && !HW_WE_EN && sww && !hw_set && !hw_clr && HSEL == SEL_ALL)
        |=> fld_q == $past(hw_d)); // R9

    AST_PULSE_DROP: assert property (@(posedge clk) disable iff (rst_act)
        (PULSE && !sww && !rdc && !hw_set && !hw_clr && !hww) |=> fld_q == '0); // R10

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst_act)
        (rdc && (PREC == PREC_SW ? !sww : (!hw_set && !hw_clr && !hww && !sww)))
        |=> fld_q == '0); // R11

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst_act |=> fld_q == RST_VAL); // R8

endmodule

bind regfld_arbiter rfa_chk #(
    .BUS_W(BUS_W), .FLD_W(FLD_W), .RST_VAL(RST_VAL), .PREC(PREC), .WFX(WFX),
    .RD_CLR(RD_CLR), .PULSE(PULSE), .HW_WE_EN(HW_WE_EN), .HSEL(HSEL),
    .QUAL(QUAL), .RST_LOW(RST_LOW)
) u_rfa_chk (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_be(sw_be),
    .wd_fld(sw_wdata[FLD_LSB +: FLD_W]), .sw_wen(sw_wen), .sw_rd(sw_rd),
    .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set), .hw_clr(hw_clr), .fld_q(fld_q)
);

// File: tb/test_regfld_arbiter.sv
`timescale 1ns/1ps
module test_regfld_arbiter;
    import rfa_pkg::*;

    localparam logic [11:0] RST = 12'h5A3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_n_c = 1'b0;
    logic        sw_wr = 0, sw_wen = 0, sw_rd = 0, hw_we = 0, hw_set = 0, hw_clr = 0;
    logic [3:0]  sw_be = '0;
    logic [31:0] sw_wdata = '0;
    logic [11:0] hw_d = '0, hw_bitsel = '0;
    logic [11:0] qa, qb, qc, qd;
    logic [11:0] ea = '0, eb = '0, ec = '0, ed = '0;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    // A: sw precedence, plain, enable select, active-high qualifier
    regfld_arbiter i_regfld_arbiter (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_be(sw_be), .sw_wdata(sw_wdata),
        .sw_wen(sw_wen), .sw_rd(sw_rd), .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set),
        .hw_clr(hw_clr), .hw_bitsel(hw_bitsel), .fld_q(qa));

    // B: hw precedence, write-one-to-clear, clear on read, mask select, active-low qualifier
    regfld_arbiter #(.PREC(PREC_HW), .WFX(WFX_W1C), .RD_CLR(1'b1), .HSEL(SEL_MASK),
        .QUAL(QUAL_LOW)) i_regfld_arbiter_b (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_be(sw_be), .sw_wdata(sw_wdata),
        .sw_wen(sw_wen), .sw_rd(sw_rd), .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set),
        .hw_clr(hw_clr), .hw_bitsel(hw_bitsel), .fld_q(qb));

    // C: single pulse, async active-low reset
    regfld_arbiter #(.PULSE(1'b1), .HSEL(SEL_ALL), .QUAL(QUAL_NONE), .RST_ASYNC(1'b1),
        .RST_LOW(1'b1)) i_regfld_arbiter_c (
        .clk(clk), .rst(rst_n_c), .sw_wr(sw_wr), .sw_be(sw_be), .sw_wdata(sw_wdata),
        .sw_wen(sw_wen), .sw_rd(sw_rd), .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set),
        .hw_clr(hw_clr), .hw_bitsel(hw_bitsel), .fld_q(qc));

    // D: hw precedence with no hw write enable, write-one-to-set
    regfld_arbiter #(.PREC(PREC_HW), .WFX(WFX_W1S), .HW_WE_EN(1'b0), .HSEL(SEL_ALL),
        .QUAL(QUAL_NONE)) i_regfld_arbiter_d (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_be(sw_be), .sw_wdata(sw_wdata),
        .sw_wen(sw_wen), .sw_rd(sw_rd), .hw_we(hw_we), .hw_d(hw_d), .hw_set(hw_set),
        .hw_clr(hw_clr), .hw_bitsel(hw_bitsel), .fld_q(qd));

    // reference: hwp 0/1; fx 0 plain 1 w1c 2 w1s; bsel 0 all 1 enable 2 mask; qual 0 none 1 high 2 low
    function automatic logic [11:0] mdl(input int hwp, input int fx, input int rdc,
        input int pls, input int hwwe, input int bsel, input int qual, input logic [11:0] q);
        logic [11:0] wd, swv, sel, scv, hwv;
        logic sww, swr, hsc, hww;
        wd = sw_wdata[15:4];
        for (int i = 0; i < 12; i++) swv[i] = sw_be[(i + 4) / 8] ? wd[i] : q[i];
        if (fx == 1) swv = q & ~wd;
        if (fx == 2) swv = q | wd;
        sww = sw_wr && (qual == 0 || (qual == 1 && sw_wen) || (qual == 2 && !sw_wen));
        swr = (rdc != 0) && sw_rd;
        sel = (bsel == 0) ? 12'hFFF : (bsel == 1) ? hw_bitsel : ~hw_bitsel;
        hsc = hw_set || hw_clr;
        scv = hw_set ? (q | sel) : (q & ~sel);
        hww = (hwwe != 0) ? hw_we : 1'b1;
        hwv = (q & ~sel) | (hw_d & sel);
        if (hwp == 0) begin
            if (sww) return swv;
            if (swr) return '0;
            if (hsc) return scv;
            if (hww) return hwv;
        end else begin
            if (hsc) return scv;
            if (hww) return hwv;
            if (sww) return swv;
            if (swr) return '0;
        end
        if (pls != 0) return '0;
        return q;
    endfunction

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sw_wr = 0; sw_be = '0; sw_wdata = '0; sw_wen = 0; sw_rd = 0;
        hw_we = 0; hw_d = '0; hw_set = 0; hw_clr = 0; hw_bitsel = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        ea = rst ? RST : mdl(0, 0, 0, 0, 1, 1, 1, ea);
        eb = rst ? RST : mdl(1, 1, 1, 0, 1, 2, 2, eb);
        ec = !rst_n_c ? RST : mdl(0, 0, 0, 1, 1, 0, 0, ec);
        ed = rst ? RST : mdl(1, 2, 0, 0, 0, 0, 0, ed);
        @(negedge clk);
        chk("R1 (instance A)", qa, ea);
        chk("R2 (instance B)", qb, eb);
        chk("R10 (instance C)", qc, ec);
        chk("R9 (instance D)", qd, ed);
    endtask

    task automatic rnd();
        sw_wr = ($urandom % 4) == 0;
        sw_be = 4'($urandom);
        sw_wdata = $urandom;
        sw_wen = ($urandom % 4) != 0;
        sw_rd = ($urandom % 5) == 0;
        hw_we = ($urandom % 4) == 0;
        hw_d = 12'($urandom);
        hw_set = ($urandom % 10) == 0;
        hw_clr = ($urandom % 10) == 0;
        hw_bitsel = 12'($urandom);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        idle();
        @(negedge clk);
        repeat (3) cyc();
        chk("R8 reset A", qa, RST);
        chk("R8 reset B", qb, RST);
        chk("R8 reset C", qc, RST);
        chk("R8 reset D", qd, RST);
        rst = 0; rst_n_c = 1;

        // R3: only lane 0 enabled -> field bits 0..3 written
        sw_wr = 1; sw_be = 4'b0001; sw_wdata = 32'h0000_00F0; sw_wen = 1;
        cyc(); chk("R3 lane write", qa, 12'h5AF);

        // R6 on A (qualifier low blocks), R7 w1c on B (active-low qualifier passes)
        idle(); sw_wr = 1; sw_be = 4'hF; sw_wdata = 32'hFFFF_FFFF; sw_wen = 0;
        cyc(); chk("R6 qualifier blocks", qa, 12'h5AF); chk("R7 w1c", qb, 12'h000);

        // R4 set beats clear on selected bits; R5 mask mode on B
        idle(); hw_set = 1; hw_clr = 1; hw_bitsel = 12'hF00;
        cyc(); chk("R4 set selected", qa, 12'hFAF); chk("R5 mask select", qb, 12'h0FF);

        idle(); hw_clr = 1; hw_bitsel = 12'h0F0;
        cyc(); chk("R4 clear selected", qa, 12'hF0F); chk("R5 mask clear", qb, 12'h0F0);

        // R11: value visible during strobe, cleared after
        idle(); sw_rd = 1; #1;
        chk("R11 pre-clear read", qb, 12'h0F0);
        cyc(); chk("R11 cleared", qb, 12'h000); chk("R11 no clear on A", qa, 12'hF0F);

        // R1 collision: sw write beats set and hw write; R2 set wins on D
        idle(); sw_wr = 1; sw_be = 4'hF; sw_wdata = 32'h0000_1230; sw_wen = 1;
        hw_we = 1; hw_d = 12'hFFF; hw_set = 1; hw_bitsel = 12'hFFF;
        cyc(); chk("R1 sw wins", qa, 12'h123); chk("R2 set wins", qd, 12'hFFF);

        // R9: no hw write enable, hw value streams in, sw ignored
        idle(); hw_d = 12'h3C3; sw_wr = 1; sw_be = 4'hF; sw_wdata = 32'hFFFF_FFFF; sw_wen = 1;
        cyc(); chk("R9 hw streams", qd, 12'h3C3);

        // R10: single pulse
        idle(); sw_wr = 1; sw_be = 4'hF; sw_wdata = 32'h0000_0050;
        cyc(); chk("R10 pulse high", qc, 12'h005);
        idle();
        cyc(); chk("R10 pulse low", qc, 12'h000);

        // R8: asynchronous reset acts before the clock edge
        rst_n_c = 0; #1;
        chk("R8 async reset", qc, RST);
        cyc();
        rst_n_c = 1;

        for (int n = 0; n < 3000; n++) begin
            rnd();
            cyc();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule